// File: doc/BRIEF.md
# Fabric and LCD Clock-Enable Divider with Subdomain Gating

This block derives the clock timing of a bus-fabric domain and of an LCD controller from one input clock. Both are modelled as single-cycle clock-enable pulses inside that one clock domain. Each of the two rates comes from its own power-of-two divider, selecting divide by 1, 2, 4 or 8. A bank of gate bits then passes or blocks the enable for each subdomain. The subdomains are the fabric with its ports, the system DMA, the host port interface, the peripheral bridge, the LCD controller, and two exported copies of the fabric enable.

Software programs the block through a small synchronous write port with a separate combinational read port. Each subdomain comes out of reset in its own on or off state. A divide change never cuts a period short: it is taken up only when the current divided period ends. A toggle strobe for the external LCD interface follows the ungated fabric rate, so it keeps running while the DMA enable is gated off.

Top module: `fabric_clk_ctl`

## Requirements
- R1: The ungated fabric enable `fab_tick` asserts for one cycle out of every N, where N is chosen by divide-register (address 0) bits [1:0]: 00 selects 1, 01 selects 2, 10 selects 4 and 11 selects 8.
- R2: The LCD rate is chosen by divide-register bits [3:2], with the same encoding. It is independent of the fabric field, and `lcd_ce` pulses once every N cycles of the LCD rate while the LCD is enabled.
- R3: After reset both divide fields are 00, so `fab_tick` asserts on every cycle, and address 0 reads 0.
- R4: After reset the gate register (address 1) reads 0x69. The fabric-ports, bridge and both export enables run. The DMA, host port and LCD enables are off.
- R5: Gate bits of address 1 are: bit 0 fabric/ports, bit 1 DMA, bit 2 host port, bit 3 bridge, bit 4 LCD. A gated output pulses exactly when its bit is 1 and its source rate ticks. The LCD output uses the LCD rate; all the others use the fabric rate.
- R6: The exported copies `exp_a_ce` (bit 5) and `exp_b_ce` (bit 6) run at the fabric rate, and each can be switched off without affecting the other.
- R7: `lcdif_toggle` inverts on every fabric tick, whatever the gate bits hold.
- R8: A new divide value takes effect only at the end of the current divided period. Every gap between consecutive `fab_tick` pulses therefore equals either the old or the new period.
- R9: Reads return the divide fields at address 0 and the gate bits at address 1. Reserved bits and unused addresses read 0, and writes to reserved bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| fab_tick | output | 1 | Ungated fabric-rate enable |
| fab_ce | output | 1 | Gated enable, fabric and ports |
| dma_ce | output | 1 | Gated enable, system DMA |
| host_ce | output | 1 | Gated enable, host port interface |
| bridge_ce | output | 1 | Gated enable, peripheral bridge |
| lcd_ce | output | 1 | Gated enable, LCD rate |
| exp_a_ce | output | 1 | Exported fabric enable A |
| exp_b_ce | output | 1 | Exported fabric enable B |
| lcdif_toggle | output | 1 | Free-running LCD interface strobe |

## Verification
The bench drives a scoreboard of expected pulse counts over aligned 64-cycle windows. It covers every divide setting, mixed fabric and LCD rates, and gate patterns, including all gates off. A design that fed the LCD enable from the fabric divider, or that stopped the strobe with the DMA gate, would show wrong counts. The bench also follows a divide change from 8 to 2 and measures every gap between pulses. Reloading the counter on the write would show up as a gap that matches neither period. Reads of the reset values, of writes with reserved bits set, and of an unused address catch a wrong reset mask or a field stored at the wrong bit position.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
    localparam int SEL_W     = 2;
    localparam int NUM_GATES = 7;
    localparam int G_FAB     = 0;
    localparam int G_DMA     = 1;
    localparam int G_HOST    = 2;
    localparam int G_BRIDGE  = 3;
    localparam int G_LCD     = 4;
    localparam int G_EXPA    = 5;
    localparam int G_EXPB    = 6;
    localparam logic [NUM_GATES-1:0] GATE_RST = 7'h69;

    typedef struct packed {
        logic [SEL_W-1:0]     lcd_div;
        logic [SEL_W-1:0]     fab_div;
        logic [NUM_GATES-1:0] gate;
    } cfg_t;
endpackage

// File: rtl/fclk_cfg_regs.sv
module fclk_cfg_regs
    import fclk_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg
);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(1);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == A_DIV) begin
                cfg_d.fab_div = wr_data[SEL_W-1:0];
                cfg_d.lcd_div = wr_data[2*SEL_W-1:SEL_W];
            end else if (wr_addr == A_GATE) begin
                cfg_d.gate = wr_data[NUM_GATES-1:0];
            end
        end
        rd_data = '0;
        if (rd_addr == A_DIV)
            rd_data[2*SEL_W-1:0] = {cfg_q.lcd_div, cfg_q.fab_div};
        else if (rd_addr == A_GATE)
            rd_data[NUM_GATES-1:0] = cfg_q.gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.fab_div <= '0;
            cfg_q.lcd_div <= '0;
            cfg_q.gate    <= GATE_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R9: a register changes only through a write to its address
    a_r9_gate_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_GATE) |=> $stable(cfg_q.gate));
endmodule

// File: rtl/fclk_pow2_div.sv
module fclk_pow2_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_in,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CNT_W:0]   one_hot;
    logic [CNT_W-1:0] last;

    always_comb begin
        one_hot = (CNT_W+1)'(1) << st_q.sel;
        last    = CNT_W'(one_hot - (CNT_W+1)'(1));
        tick    = (st_q.cnt == last);
        st_d    = st_q;
        if (tick) begin
            st_d.cnt = '0;
            st_d.sel = sel_in;     // new ratio only at a period boundary
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // checker: cycles elapsed since the previous pulse
    logic [CNT_W:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    gap_q <= '0;
        else if (tick) gap_q <= '0;
        else           gap_q <= gap_q + (CNT_W+1)'(1);
    end

    // R1 R8: each period is exactly the ratio in force, never shortened
    a_r8_full_period: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q + (CNT_W+1)'(1)) == ((CNT_W+1)'(1) << st_q.sel));
endmodule

// File: rtl/fabric_clk_ctl.sv
module fabric_clk_ctl
    import fclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        fab_tick,
    output logic        fab_ce,
    output logic        dma_ce,
    output logic        host_ce,
    output logic        bridge_ce,
    output logic        lcd_ce,
    output logic        exp_a_ce,
    output logic        exp_b_ce,
    output logic        lcdif_toggle
);
    localparam int NUM_DIV = 2;
    localparam int D_FAB   = 0;
    localparam int D_LCD   = 1;

    cfg_t cfg;
    logic [SEL_W-1:0]     div_sel [NUM_DIV];
    logic [NUM_DIV-1:0]   ticks;
    logic [NUM_GATES-1:0] gated;

    fclk_cfg_regs #(.DATA_W(32), .ADDR_W(2)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    assign div_sel[D_FAB] = cfg.fab_div;
    assign div_sel[D_LCD] = cfg.lcd_div;

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        fclk_pow2_div #(.SEL_W(SEL_W)) i_div (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_in (div_sel[d]),
            .tick   (ticks[d])
        );
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        if (g == G_LCD) begin : g_lcd_src
            assign gated[g] = cfg.gate[g] & ticks[D_LCD];
        end else begin : g_fab_src
            assign gated[g] = cfg.gate[g] & ticks[D_FAB];
        end
    end

    typedef struct packed { logic tog; } strobe_st_t;
    strobe_st_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        if (ticks[D_FAB]) sb_d.tog = ~sb_q.tog;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    assign fab_tick     = ticks[D_FAB];
    assign fab_ce       = gated[G_FAB];
    assign dma_ce       = gated[G_DMA];
    assign host_ce      = gated[G_HOST];
    assign bridge_ce    = gated[G_BRIDGE];
    assign lcd_ce       = gated[G_LCD];
    assign exp_a_ce     = gated[G_EXPA];
    assign exp_b_ce     = gated[G_EXPB];
    assign lcdif_toggle = sb_q.tog;

    // R5: fabric-sourced enables never pulse off the fabric rate
    a_r5_gated_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ce | host_ce | bridge_ce | fab_ce) |-> fab_tick);

    // R6: exported copies only pulse with the fabric rate
    a_r6_export_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_a_ce | exp_b_ce) |-> fab_tick);

    // R7: strobe inverts after every fabric tick, gating notwithstanding
    a_r7_strobe_runs: assert property (@(posedge clk) disable iff (!rst_n)
        fab_tick |=> lcdif_toggle != $past(lcdif_toggle));

    // R4: first cycle out of reset has DMA, host and LCD enables off
    a_r4_reset_gates: assert property (@(posedge clk)
        (rst_n && $past(!rst_n)) |-> (!dma_ce && !host_ce && !lcd_ce && fab_ce && bridge_ce));
endmodule

// File: tb/test_fabric_clk_ctl.sv
`timescale 1ns/1ps
module test_fabric_clk_ctl;
    localparam int WIN = 64;
    localparam int NOUT = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic fab_tick, fab_ce, dma_ce, host_ce, bridge_ce, lcd_ce, exp_a_ce, exp_b_ce, lcdif_toggle;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_q[$];
    string tag_q[$];
    int win_done = 0;

    always #2 clk = ~clk;

    fabric_clk_ctl i_fabric_clk_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fab_tick(fab_tick), .fab_ce(fab_ce),
        .dma_ce(dma_ce), .host_ce(host_ce), .bridge_ce(bridge_ce), .lcd_ce(lcd_ce),
        .exp_a_ce(exp_a_ce), .exp_b_ce(exp_b_ce), .lcdif_toggle(lcdif_toggle)
    );

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] a, int expv);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(req, $sformatf("read addr %0d", a), int'(rd_data), expv);
    endtask

    // driver: push expected pulse counts for one window, wait for monitor
    task automatic expect_window(string tag, int fdiv, int ldiv, logic [6:0] g);
        int nf = WIN / (1 << fdiv);
        int nl = WIN / (1 << ldiv);
        int start = win_done;
        wr(2'd0, {28'd0, 2'(ldiv), 2'(fdiv)});
        wr(2'd1, {25'd0, g});
        repeat (20) @(negedge clk);
        exp_q.push_back(nf);                 // R1 fab_tick
        exp_q.push_back(g[0] ? nf : 0);      // R5 fab_ce
        exp_q.push_back(g[1] ? nf : 0);      // R5 dma_ce
        exp_q.push_back(g[2] ? nf : 0);      // R5 host_ce
        exp_q.push_back(g[3] ? nf : 0);      // R5 bridge_ce
        exp_q.push_back(g[4] ? nl : 0);      // R2 lcd_ce
        exp_q.push_back(g[5] ? nf : 0);      // R6 exp_a_ce
        exp_q.push_back(g[6] ? nf : 0);      // R6 exp_b_ce
        exp_q.push_back(nf);                 // R7 toggles
        tag_q.push_back(tag);
        wait (win_done != start);
    endtask

    // monitor: pop expected counts, count observed pulses over a window
    initial begin
        string names[NOUT] = '{"R1 fab_tick", "R5 fab_ce", "R5 dma_ce", "R5 host_ce",
                               "R5 bridge_ce", "R2 lcd_ce", "R6 exp_a_ce", "R6 exp_b_ce",
                               "R7 lcdif_toggle"};
        forever begin
            int cnt[NOUT];
            int expv[NOUT];
            string tag;
            logic prev_tog;
            wait (tag_q.size() != 0);
            tag = tag_q.pop_front();
            for (int i = 0; i < NOUT; i++) begin
                expv[i] = exp_q.pop_front();
                cnt[i] = 0;
            end
            @(negedge clk);
            prev_tog = lcdif_toggle;
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                cnt[0] += int'(fab_tick);
                cnt[1] += int'(fab_ce);
                cnt[2] += int'(dma_ce);
                cnt[3] += int'(host_ce);
                cnt[4] += int'(bridge_ce);
                cnt[5] += int'(lcd_ce);
                cnt[6] += int'(exp_a_ce);
                cnt[7] += int'(exp_b_ce);
                cnt[8] += int'(lcdif_toggle != prev_tog);
                prev_tog = lcdif_toggle;
            end
            for (int i = 0; i < NOUT; i++)
                check(names[i], tag, cnt[i], expv[i]);
            win_done++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    // R8: divide 8 -> 2 change, every gap must be 8 or 2
    task automatic transition_check();
        int last_t = -1;
        int t = 0;
        int bad = 0;
        int saw_new = 0;
        wr(2'd0, 32'h3);
        repeat (20) @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (fab_tick) begin
                if (last_t >= 0) begin
                    if ((t - last_t) != 8 && (t - last_t) != 2) bad++;
                    if ((t - last_t) == 2) saw_new++;
                end
                last_t = t;
            end
            t++;
        end
        check("R8", "gaps neither old nor new period", bad, 0);
        check("R8", "new period reached", int'(saw_new > 0), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R4 reset state on the first cycle after reset
        check("R3", "fab_tick after reset", int'(fab_tick), 1);
        check("R4", "fab_ce after reset", int'(fab_ce), 1);
        check("R4", "bridge_ce after reset", int'(bridge_ce), 1);
        check("R4", "exp_a_ce after reset", int'(exp_a_ce), 1);
        check("R4", "exp_b_ce after reset", int'(exp_b_ce), 1);
        check("R4", "dma_ce after reset", int'(dma_ce), 0);
        check("R4", "host_ce after reset", int'(host_ce), 0);
        check("R4", "lcd_ce after reset", int'(lcd_ce), 0);
        rd_check("R3", 2'd0, 0);
        rd_check("R4", 2'd1, 32'h69);
        expect_window("reset config", 0, 0, 7'h69);
        expect_window("fab/2 lcd/1 all on", 1, 0, 7'h7F);
        expect_window("fab/4 lcd/8 all on", 2, 3, 7'h7F);
        expect_window("fab/8 lcd/2 dma+bridge+lcd", 3, 1, 7'h1A);
        expect_window("all gated off, R7 strobe", 0, 2, 7'h00);
        expect_window("export A only", 1, 1, 7'h21);
        expect_window("export B only", 2, 0, 7'h41);
        // R9 reserved bits ignored, unused address reads zero
        wr(2'd0, 32'hFFFF_FFF6);
        rd_check("R9", 2'd0, 32'h6);
        wr(2'd1, 32'hFFFF_FF95);
        rd_check("R9", 2'd1, 32'h15);
        wr(2'd2, 32'hFFFF_FFFF);
        rd_check("R9", 2'd2, 0);
        rd_check("R9", 2'd0, 32'h6);
        transition_check();
        finish_run();
    end
endmodule